// File: doc/BRIEF.md
# Two-Byte Bus Register Peripheral

This block is a small peripheral that hangs on the external bus of a microcontroller running with its memory bus brought out. It holds two byte-wide storage registers at two neighbouring addresses inside an address region that on-chip memory leaves free, so its decode never collides with internal resources. The address arrives already separated from the data (demultiplexing happens upstream), and the block follows the bus cycle timing set by the E strobe. The E strobe is high during the data phase of every cycle. The block samples E with its own clock and treats the cycle in which E is seen low after having been high as the end of the bus cycle.

A write cycle loads the addressed register or registers from the data bus at that end of cycle. A read cycle drives the register contents onto the data bus, with an output enable, for as long as E is high. One bus cycle carries either one byte or a full 16-bit word, chosen by address bit 0 together with an active-low lane strobe. The even address uses the upper half of the data bus and the odd address uses the lower half. Both register values also appear continuously on parallel output pins.

Top module: `bus_pair_regs`

## Requirements
- R1: While `rst` is high and after it is released, both registers read 0x00 on `reg_hi_q`/`reg_lo_q` and `bus_data_oe` is low until an access.
- R2: A write cycle (`bus_rw`=0) to `BASE_ADDR` (0x4000) with `bus_lstrb_n`=0 loads `reg_hi_q` from `bus_data_in[15:8]` and `reg_lo_q` from `bus_data_in[7:0]`.
- R3: A write cycle to 0x4000 with `bus_lstrb_n`=1 loads only `reg_hi_q` from `bus_data_in[15:8]`, and `reg_lo_q` keeps its value.
- R4: A write cycle to 0x4001 with `bus_lstrb_n`=0 loads only `reg_lo_q` from `bus_data_in[7:0]`, and `reg_hi_q` keeps its value.
- R5: A register changes only at the falling edge of E, meaning the first clock edge at which `bus_e` is sampled low after being sampled high. It does not change while E stays high or stays low. The new value is visible one clock later.
- R6: Any address other than 0x4000 and 0x4001 leaves both registers unchanged and never raises `bus_data_oe`.
- R7: `bus_data_oe` is high exactly while `bus_e`=1, `bus_rw`=1 and the access selects at least one register. `bus_data_out[15:8]` then carries `reg_hi_q` if the high lane is selected, `bus_data_out[7:0]` carries `reg_lo_q` if the low lane is selected, and an unselected lane is 0.
- R8: When `bus_data_oe` is low, `bus_data_out` is all zeros.
- R9: An access to 0x4001 with `bus_lstrb_n`=1 selects no lane. It neither writes nor drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Demultiplexed bus address |
| bus_data_in | input | 16 | Data bus as seen by the peripheral |
| bus_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_e | input | 1 | Bus cycle strobe, high in data phase |
| bus_lstrb_n | input | 1 | Active-low low-lane strobe |
| reg_hi_q | output | 8 | Register at the even address |
| reg_lo_q | output | 8 | Register at the odd address |
| bus_data_out | output | 16 | Read data toward the bus |
| bus_data_oe | output | 1 | Read data drive enable |

## Verification
The hardest situation to reach is a register update that lands in the wrong clock. The write must take effect only at the sampled E falling edge and never during the E-high phase, while the address, strobe and data stay stable. Each stimulus cycle holds its inputs one clock past the E fall and checks the registers both in the middle of the high phase and after the fall. Random cycles mix the two window addresses with neighbouring and far addresses and with all strobe and direction combinations, which also covers the odd-address, strobe-high case that selects nothing.

// File: rtl/bus_pair_pkg.sv
package bus_pair_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int BYTE_W = DATA_W / 2;

    typedef struct packed {
        logic hi;
        logic lo;
    } lane_sel_t;

    typedef enum logic [1:0] {
        XFER_NONE = 2'd0,
        XFER_HI   = 2'd1,
        XFER_LO   = 2'd2,
        XFER_WORD = 2'd3
    } xfer_kind_t;

    function automatic xfer_kind_t classify(input logic a0, input logic lstrb_n);
        xfer_kind_t k;
        case ({a0, lstrb_n})
            2'b00:   k = XFER_WORD;
            2'b01:   k = XFER_HI;
            2'b10:   k = XFER_LO;
            default: k = XFER_NONE;
        endcase
        return k;
    endfunction

    function automatic lane_sel_t lanes_of(input xfer_kind_t k);
        lane_sel_t s;
        s.hi = (k == XFER_WORD) || (k == XFER_HI);
        s.lo = (k == XFER_WORD) || (k == XFER_LO);
        return s;
    endfunction

endpackage

// File: rtl/bus_pair_decode.sv
module bus_pair_decode
    import bus_pair_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              lstrb_n,
    output logic              win_hit,
    output lane_sel_t         lanes
);
    localparam logic [ADDR_W-2:0] BASE_PAIR = BASE_ADDR[ADDR_W-1:1];

    xfer_kind_t kind;
    logic       pair_match;

    always_comb begin
        pair_match = (addr[ADDR_W-1:1] == BASE_PAIR);
        kind       = classify(addr[0], lstrb_n);
        lanes      = pair_match ? lanes_of(kind) : '0;
        win_hit    = lanes.hi | lanes.lo;
    end
endmodule

// File: rtl/bus_pair_strobe.sv
module bus_pair_strobe (
    input  logic clk,
    input  logic rst,
    input  logic e_in,
    output logic e_fall
);
    logic e_q;

    always_ff @(posedge clk) begin
        if (rst) e_q <= 1'b0;
        else     e_q <= e_in;
    end

    assign e_fall = e_q & ~e_in;
endmodule

// File: rtl/bus_pair_regfile.sv
module bus_pair_regfile
    import bus_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lane_sel_t         wr_lanes,
    input  logic [DATA_W-1:0] wdata,
    output logic [BYTE_W-1:0] hi_q,
    output logic [BYTE_W-1:0] lo_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (wr_lanes.hi) hi_q <= wdata[DATA_W-1:BYTE_W];
            if (wr_lanes.lo) lo_q <= wdata[BYTE_W-1:0];
        end
    end

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_lanes.hi || wr_lanes.lo) |=> $stable({hi_q, lo_q}));

    // R2
    hi_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_lanes.hi |=> hi_q == $past(wdata[DATA_W-1:BYTE_W]));

    // R4
    lo_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_lanes.lo |=> lo_q == $past(wdata[BYTE_W-1:0]));
endmodule

// File: rtl/bus_pair_regs.sv
module bus_pair_regs
    import bus_pair_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h4000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] bus_addr,
    input  logic [15:0] bus_data_in,
    input  logic        bus_rw,
    input  logic        bus_e,
    input  logic        bus_lstrb_n,
    output logic [7:0]  reg_hi_q,
    output logic [7:0]  reg_lo_q,
    output logic [15:0] bus_data_out,
    output logic        bus_data_oe
);
    logic      win_hit;
    lane_sel_t lanes;
    lane_sel_t wr_lanes;
    logic      e_fall;
    logic      rd_active;

    bus_pair_decode #(.BASE_ADDR(BASE_ADDR)) u_decode (
        .addr    (bus_addr),
        .lstrb_n (bus_lstrb_n),
        .win_hit (win_hit),
        .lanes   (lanes)
    );

    bus_pair_strobe u_strobe (
        .clk    (clk),
        .rst    (rst),
        .e_in   (bus_e),
        .e_fall (e_fall)
    );

    always_comb begin
        wr_lanes.hi = lanes.hi & e_fall & ~bus_rw;
        wr_lanes.lo = lanes.lo & e_fall & ~bus_rw;
    end

    bus_pair_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_lanes (wr_lanes),
        .wdata    (bus_data_in),
        .hi_q     (reg_hi_q),
        .lo_q     (reg_lo_q)
    );

    always_comb begin
        rd_active    = bus_e & bus_rw & win_hit;
        bus_data_oe  = rd_active;
        bus_data_out = '0;
        if (rd_active) begin
            if (lanes.hi) bus_data_out[15:8] = reg_hi_q;
            if (lanes.lo) bus_data_out[7:0]  = reg_lo_q;
        end
    end

    // R6
    no_drive_outside_chk: assert property (@(posedge clk) disable iff (rst)
        !win_hit |-> !bus_data_oe);

    // R7
    oe_needs_read_phase_chk: assert property (@(posedge clk) disable iff (rst)
        bus_data_oe |-> (bus_e && bus_rw));

    // R8
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_data_oe |-> (bus_data_out == 16'h0000));

    // R5
    no_write_while_e_high_chk: assert property (@(posedge clk) disable iff (rst)
        bus_e |=> $stable({reg_hi_q, reg_lo_q}));
endmodule

// File: tb/bus_pair_regs_bench.sv
module bus_pair_regs_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_addr;
    logic [15:0] bus_data_in;
    logic        bus_rw;
    logic        bus_e;
    logic        bus_lstrb_n;
    logic [7:0]  reg_hi_q;
    logic [7:0]  reg_lo_q;
    logic [15:0] bus_data_out;
    logic        bus_data_oe;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_hi = 8'h00;
    logic [7:0] exp_lo = 8'h00;
    logic done = 1'b0;

    always #10 clk = ~clk;

    bus_pair_regs u_bus_pair_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data_in(bus_data_in),
        .bus_rw(bus_rw), .bus_e(bus_e), .bus_lstrb_n(bus_lstrb_n),
        .reg_hi_q(reg_hi_q), .reg_lo_q(reg_lo_q),
        .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe)
    );

    function automatic logic sel_hi(input logic [15:0] a, input logic ls);
        return (a == 16'h4000);
    endfunction

    function automatic logic sel_lo(input logic [15:0] a, input logic ls);
        return ((a == 16'h4000) && !ls) || ((a == 16'h4001) && !ls);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic [15:0] a, input logic rw,
                             input logic ls, input logic [15:0] d, input string req);
        logic h, l;
        logic [15:0] exp_out;
        h = sel_hi(a, ls);
        l = sel_lo(a, ls);
        @(negedge clk);
        bus_addr = a; bus_rw = rw; bus_lstrb_n = ls; bus_data_in = d; bus_e = 1'b0;
        @(negedge clk);
        bus_e = 1'b1;
        @(negedge clk);
        // R5: nothing changes while E is high; R7/R8 read drive
        check({req, " R5 hold in E-high"}, {16'h0, reg_hi_q, reg_lo_q}, {16'h0, exp_hi, exp_lo});
        exp_out = 16'h0;
        if (rw && h) exp_out[15:8] = exp_hi;
        if (rw && l) exp_out[7:0]  = exp_lo;
        check({req, " R7 oe"}, {31'h0, bus_data_oe}, {31'h0, rw && (h || l)});
        check({req, " R7 R8 data_out"}, {16'h0, bus_data_out}, {16'h0, exp_out});
        @(negedge clk);
        bus_e = 1'b0;
        @(negedge clk);
        if (!rw) begin
            if (h) exp_hi = d[15:8];
            if (l) exp_lo = d[7:0];
        end
        check({req, " regs after E fall"}, {16'h0, reg_hi_q, reg_lo_q}, {16'h0, exp_hi, exp_lo});
        check({req, " R8 idle out"}, {15'h0, bus_data_oe, bus_data_out}, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] ra;
        int seed_dummy;
        rst = 1'b1; bus_addr = 16'h0; bus_data_in = 16'hFFFF; bus_rw = 1'b0;
        bus_e = 1'b0; bus_lstrb_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 regs in reset", {16'h0, reg_hi_q, reg_lo_q}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {15'h0, bus_data_oe, reg_hi_q, reg_lo_q}, 32'h0);

        bus_cycle(16'h4000, 1'b0, 1'b0, 16'hA55A, "R2 word write");
        bus_cycle(16'h4000, 1'b1, 1'b0, 16'h0000, "R2 R7 word read");
        bus_cycle(16'h4000, 1'b0, 1'b1, 16'h3C99, "R3 high byte write");
        bus_cycle(16'h4000, 1'b1, 1'b1, 16'h0000, "R3 R7 high byte read");
        bus_cycle(16'h4001, 1'b0, 1'b0, 16'h77E1, "R4 low byte write");
        bus_cycle(16'h4001, 1'b1, 1'b0, 16'h0000, "R4 R7 low byte read");
        bus_cycle(16'h4001, 1'b0, 1'b1, 16'hFFFF, "R9 odd strobe-high write");
        bus_cycle(16'h4001, 1'b1, 1'b1, 16'h0000, "R9 odd strobe-high read");
        bus_cycle(16'h4002, 1'b0, 1'b0, 16'h1234, "R6 neighbour write");
        bus_cycle(16'h3FFF, 1'b1, 1'b0, 16'h0000, "R6 below window read");
        bus_cycle(16'hC000, 1'b0, 1'b0, 16'h5678, "R6 far write");

        // R5: E held high over many clocks with a write pending
        @(negedge clk);
        bus_addr = 16'h4000; bus_rw = 1'b0; bus_lstrb_n = 1'b0; bus_data_in = 16'h0F0F; bus_e = 1'b1;
        repeat (5) @(negedge clk);
        check("R5 long E-high no write", {16'h0, reg_hi_q, reg_lo_q}, {16'h0, exp_hi, exp_lo});
        bus_e = 1'b0;
        @(negedge clk);
        exp_hi = 8'h0F; exp_lo = 8'h0F;
        check("R5 write at E fall", {16'h0, reg_hi_q, reg_lo_q}, {16'h0, exp_hi, exp_lo});
        bus_data_in = 16'hEEEE;
        repeat (3) @(negedge clk);
        check("R5 E low no further write", {16'h0, reg_hi_q, reg_lo_q}, {16'h0, exp_hi, exp_lo});

        seed_dummy = $urandom(32'd1234);
        for (int i = 0; i < 300; i++) begin
            case ($urandom_range(0, 3))
                0: ra = 16'h4000;
                1: ra = 16'h4001;
                2: ra = 16'h3FFE + 16'($urandom_range(0, 5));
                default: ra = 16'($urandom());
            endcase
            bus_cycle(ra, 1'($urandom()), 1'($urandom()), 16'($urandom()), "R2 R3 R4 R6 R7 R9 random");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule